// File: doc/BRIEF.md
# Paged Write Cache with Timed Page Commit

This block stages the data bytes of one serial write transaction before they reach a nonvolatile array. The storage is 64 bytes, arranged as 8 lines of 8 bytes. A transaction opens with a start address. The first byte always lands in line 0, at the byte offset taken from the low address bits. Each further byte moves the pointer one step through the buffer. When the pointer passes the last byte of the buffer it returns to line 0, byte 0, and later bytes overwrite what was stored there.

On a commit request, which the serial engine raises on Stop, the block walks the loaded lines in order. Line 0 goes to the array page that holds the start address, line 1 to the next page, and so on. The page number wraps modulo the page count. Each page write is a single-cycle pulse that carries the page number, the line data and a byte-enable mask. The byte-enable mask marks only the bytes that the transaction actually loaded. The pulse is followed by a fixed programming interval. `busy` stays high for the whole commit. While it is high, all load and commit inputs are ignored.

Top module: `page_stage_cache`

## Requirements
- R1: After a synchronous reset, `busy` and `pg_we` are low, and no byte is marked as loaded.
- R2: Opening a transaction with `ld_open` sets the pointer to line 0, byte offset `ld_addr[2:0]`, and latches the base page `ld_addr >> 3`. The first loaded byte is therefore committed to page `ld_addr >> 3` with byte-enable bit `ld_addr[2:0]` set.
- R3: Each accepted byte (`ld_valid` high, `ld_open` low, not busy) is stored at the pointer, and the pointer then advances by one. Stepping past byte 7 of a line moves it to byte 0 of the next line.
- R4: After byte 7 of line 7, the pointer wraps to line 0, byte 0. A 65th or later byte overwrites the byte stored earlier at that position.
- R5: When a transaction that starts at a non-zero offset fills the buffer, its final bytes land in the leading bytes of line 0. Line 0 is then committed with all 8 byte enables set.
- R6: Commit line k goes to page (base + k) modulo the page count. This holds across any row or block boundary, and across the top of the page space.
- R7: Each loaded line costs one `pg_we` pulse, which comes in the first cycle of its own interval of `PROG_CYCLES` clock cycles. `busy` is high for exactly (loaded lines × `PROG_CYCLES`) cycles. It rises in the cycle after the accepted commit request.
- R8: For each page write, `pg_ben` bit b is 1 exactly when byte b of that line was loaded in the current transaction. Enabled bytes carry the last value loaded at that position.
- R9: While `busy` is high, `ld_open`, `ld_valid` and `commit_req` are ignored. They neither change the loaded data nor lengthen the commit.
- R10: A commit request with no loaded bytes leaves `busy` low and produces no page write. The loaded-byte map is cleared when a commit finishes, so a repeated commit writes nothing.
- R11: `ld_open` discards the loaded-byte map of any earlier uncommitted transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_open | input | 1 | Opens a write transaction at `ld_addr` |
| ld_addr | input | ADDR_W | Start byte address of the transaction |
| ld_valid | input | 1 | A data byte is present on `ld_data` |
| ld_data | input | 8 | Data byte to stage |
| commit_req | input | 1 | Stop seen: commit the loaded lines |
| busy | output | 1 | Commit in progress; inputs are ignored |
| pg_we | output | 1 | One-cycle page write strobe |
| pg_page | output | ADDR_W-3 | Target array page number |
| pg_data | output | 64 | Line data; byte b is in bits 8b+7..8b |
| pg_ben | output | 8 | Per-byte write enables for the page |

## Verification
The bench aims at four corner cases, one per kind of fault:
- A partial first line starting mid-page. A design that ignores the start offset or the byte map would write the wrong bytes or clobber neighbours.
- A full buffer loaded from a non-zero offset, and a 70-byte overrun. A pointer that does not wrap, or that wraps to the start offset instead of byte 0, would leave line 0 with the wrong enables or stale data.
- A transaction that starts on the top page of the space. Page arithmetic that saturates or carries incorrectly would misplace the following lines.
- Loads and commits issued during busy, plus reopened and empty transactions. Leaks here show up as extra page writes, a busy time that is too long, or an empty commit that raises busy.

// File: rtl/page_stage_cache_pkg.sv
package page_stage_cache_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_PROG = 1'b1
    } seq_state_e;

    // Width of a counter that must hold values 0..n-1 (at least 1 bit).
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/page_stage_cache_load.sv
module page_stage_cache_load
    import page_stage_cache_pkg::*;
#(
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 8,
    parameter int ADDR_W     = 12,
    localparam int OFF_W     = cnt_width(LINE_BYTES),
    localparam int LINE_W    = cnt_width(LINES),
    localparam int PAGE_W    = ADDR_W - OFF_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         accept,
    input  logic                         ld_open,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic                         ld_valid,
    input  logic [BYTE_W-1:0]            ld_data,
    input  logic                         clr_map,
    input  logic [LINE_W-1:0]            rd_line,
    output logic [LINE_BYTES*BYTE_W-1:0] line_data,
    output logic [LINE_BYTES-1:0]        line_mask,
    output logic [LINES-1:0]             line_any,
    output logic [PAGE_W-1:0]            base_page
);
    localparam int DEPTH = LINES * LINE_BYTES;
    localparam int PTR_W = LINE_W + OFF_W;

    logic [BYTE_W-1:0] store [DEPTH];
    logic [DEPTH-1:0]  loaded;
    logic [PTR_W-1:0]  wr_ptr;

    wire take_byte = accept && ld_valid && !ld_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            loaded    <= '0;
            base_page <= '0;
        end else if (clr_map) begin
            loaded <= '0;
        end else if (accept && ld_open) begin
            loaded    <= '0;
            wr_ptr    <= {{LINE_W{1'b0}}, ld_addr[OFF_W-1:0]};
            base_page <= ld_addr[ADDR_W-1:OFF_W];
        end else if (take_byte) begin
            loaded[wr_ptr] <= 1'b1;
            wr_ptr         <= wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take_byte && !clr_map) begin
            store[wr_ptr] <= ld_data;
        end
    end

    for (genvar l = 0; l < LINES; l++) begin : g_line_any
        assign line_any[l] = |loaded[l*LINE_BYTES +: LINE_BYTES];
    end

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_rd_byte
        assign line_data[b*BYTE_W +: BYTE_W] = store[{rd_line, OFF_W'(b)}];
        assign line_mask[b]                  = loaded[{rd_line, OFF_W'(b)}];
    end

    // R3: an accepted byte moves the pointer forward by exactly one (wrapping, R4)
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
        take_byte && !clr_map |=> wr_ptr == PTR_W'($past(wr_ptr) + 1'b1));

    // R11: opening a transaction empties the map and lands in line 0
    p_open_clears_r11: assert property (@(posedge clk) disable iff (rst)
        accept && ld_open && !clr_map |=> (loaded == '0) && (wr_ptr[PTR_W-1:OFF_W] == '0));

    // R9: with accept low, the map only changes by clearing
    p_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
        !accept && !clr_map |=> $stable(loaded) && $stable(wr_ptr));

endmodule

// File: rtl/page_stage_cache_seq.sv
module page_stage_cache_seq
    import page_stage_cache_pkg::*;
#(
    parameter int LINES       = 8,
    parameter int PAGE_W      = 9,
    parameter int PROG_CYCLES = 50000,
    localparam int LINE_W     = cnt_width(LINES),
    localparam int TMR_W      = cnt_width(PROG_CYCLES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_req,
    input  logic [LINES-1:0]  line_any,
    input  logic [PAGE_W-1:0] base_page,
    output logic              busy,
    output logic              pg_we,
    output logic [PAGE_W-1:0] pg_page,
    output logic [LINE_W-1:0] cur_line,
    output logic              clr_map
);
    seq_state_e       state;
    logic [TMR_W-1:0] timer;
    logic [LINE_W-1:0] next_line;
    logic             last_line;
    logic             slot_end;

    always_comb begin
        next_line = cur_line + 1'b1;
        last_line = (cur_line == LINE_W'(LINES - 1)) || !line_any[next_line];
        slot_end  = (timer == TMR_W'(PROG_CYCLES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            timer    <= '0;
            cur_line <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (commit_req && (|line_any)) begin
                        state    <= SEQ_PROG;
                        timer    <= '0;
                        cur_line <= '0;
                    end
                end
                SEQ_PROG: begin
                    if (slot_end) begin
                        timer <= '0;
                        if (last_line) begin
                            state <= SEQ_IDLE;
                        end else begin
                            cur_line <= next_line;
                        end
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy    = (state == SEQ_PROG);
    assign pg_we   = busy && (timer == '0);
    assign pg_page = base_page + PAGE_W'(cur_line);
    assign clr_map = busy && slot_end && last_line;

    // R7: a page strobe only ever appears during a commit
    p_we_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
        pg_we |-> busy);

    // R7: strobes are separated by a programming interval (PROG_CYCLES >= 2)
    p_we_gap_r7: assert property (@(posedge clk) disable iff (rst)
        pg_we |=> !pg_we);

    // R7: an accepted commit starts with a strobe in the next cycle
    p_commit_start_r7: assert property (@(posedge clk) disable iff (rst)
        !busy && commit_req && (|line_any) |=> busy && pg_we);

    // R10: an empty commit never raises busy
    p_empty_commit_r10: assert property (@(posedge clk) disable iff (rst)
        !busy && commit_req && !(|line_any) |=> !busy);

    // R6: within one commit, each new strobe targets the page after the previous one
    p_page_step_r6: assert property (@(posedge clk) disable iff (rst)
        busy && slot_end && !last_line |=> pg_we && (pg_page == PAGE_W'($past(pg_page) + 1'b1)));

endmodule

// File: rtl/page_stage_cache.sv
module page_stage_cache
    import page_stage_cache_pkg::*;
#(
    parameter int LINES       = 8,
    parameter int LINE_BYTES  = 8,
    parameter int ADDR_W      = 12,
    parameter int PROG_CYCLES = 50000,
    localparam int OFF_W      = cnt_width(LINE_BYTES),
    localparam int LINE_W     = cnt_width(LINES),
    localparam int PAGE_W     = ADDR_W - OFF_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ld_open,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic                         ld_valid,
    input  logic [BYTE_W-1:0]            ld_data,
    input  logic                         commit_req,
    output logic                         busy,
    output logic                         pg_we,
    output logic [PAGE_W-1:0]            pg_page,
    output logic [LINE_BYTES*BYTE_W-1:0] pg_data,
    output logic [LINE_BYTES-1:0]        pg_ben
);
    logic [LINES-1:0]  line_any;
    logic [PAGE_W-1:0] base_page;
    logic [LINE_W-1:0] cur_line;
    logic              clr_map;

    page_stage_cache_load #(
        .LINES      (LINES),
        .LINE_BYTES (LINE_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_load (
        .clk       (clk),
        .rst       (rst),
        .accept    (!busy),
        .ld_open   (ld_open),
        .ld_addr   (ld_addr),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data),
        .clr_map   (clr_map),
        .rd_line   (cur_line),
        .line_data (pg_data),
        .line_mask (pg_ben),
        .line_any  (line_any),
        .base_page (base_page)
    );

    page_stage_cache_seq #(
        .LINES       (LINES),
        .PAGE_W      (PAGE_W),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .commit_req (commit_req),
        .line_any   (line_any),
        .base_page  (base_page),
        .busy       (busy),
        .pg_we      (pg_we),
        .pg_page    (pg_page),
        .cur_line   (cur_line),
        .clr_map    (clr_map)
    );

    // R8: every page write carries at least one loaded byte
    p_ben_loaded_r8: assert property (@(posedge clk) disable iff (rst)
        pg_we |-> (pg_ben != '0));

    // R1: reset leaves the block idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !busy && !pg_we);

endmodule

// File: tb/page_stage_cache_tb_top.sv
module page_stage_cache_tb_top;
    localparam int LINES  = 8;
    localparam int LB     = 8;
    localparam int ADDR_W = 12;
    localparam int PROG   = 6;
    localparam int DEPTH  = LINES * LB;
    localparam int PAGES  = 1 << (ADDR_W - 3);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        nbytes;
        logic [7:0]        seed;
    } vec_t;

    // start address, byte count, data seed
    localparam vec_t VECS [6] = '{
        '{12'h018,  8'd8,  8'd1},   // aligned single page (R2, R3)
        '{12'h01A,  8'd3,  8'd2},   // partial page mid-line (R8)
        '{12'hFFA,  8'd20, 8'd3},   // top page, wraps page number (R6)
        '{12'h01A,  8'd64, 8'd4},   // full from offset 2 (R5)
        '{12'h020,  8'd70, 8'd5},   // overrun by 6 bytes (R4)
        '{12'h105,  8'd1,  8'd6}    // single byte at offset 5 (R2)
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_open = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              ld_valid = 1'b0;
    logic [7:0]        ld_data = '0;
    logic              commit_req = 1'b0;
    logic              busy;
    logic              pg_we;
    logic [ADDR_W-4:0] pg_page;
    logic [LB*8-1:0]   pg_data;
    logic [LB-1:0]     pg_ben;

    always #5 clk = ~clk;

    page_stage_cache #(
        .LINES(LINES), .LINE_BYTES(LB), .ADDR_W(ADDR_W), .PROG_CYCLES(PROG)
    ) dut_i (
        .clk(clk), .rst(rst), .ld_open(ld_open), .ld_addr(ld_addr),
        .ld_valid(ld_valid), .ld_data(ld_data), .commit_req(commit_req),
        .busy(busy), .pg_we(pg_we), .pg_page(pg_page),
        .pg_data(pg_data), .pg_ben(pg_ben)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // capture of page writes and busy time
    int              ncap = 0;
    int              busy_cnt = 0;
    logic [ADDR_W-4:0] cap_page [16];
    logic [LB*8-1:0]   cap_data [16];
    logic [LB-1:0]     cap_ben  [16];

    always @(negedge clk) begin
        if (pg_we && ncap < 16) begin
            cap_page[ncap] = pg_page;
            cap_data[ncap] = pg_data;
            cap_ben[ncap]  = pg_ben;
            ncap = ncap + 1;
        end
        if (busy) busy_cnt = busy_cnt + 1;
    end

    // reference model of the staging buffer
    logic [7:0] m_mem [DEPTH];
    bit         m_v   [DEPTH];
    int         m_pos;
    int         m_base;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic open_txn(input logic [ADDR_W-1:0] a);
        ld_open = 1'b1;
        ld_addr = a;
        @(negedge clk);
        ld_open = 1'b0;
        for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
        m_pos  = int'(a[2:0]);
        m_base = int'(a >> 3);
    endtask

    task automatic load_bytes(input int n, input logic [7:0] seed, input bit modeled);
        for (int k = 0; k < n; k++) begin
            ld_valid = 1'b1;
            ld_data  = 8'(seed * 37 + k);
            if (modeled) begin
                m_mem[m_pos] = ld_data;
                m_v[m_pos]   = 1'b1;
                m_pos        = (m_pos + 1) % DEPTH;
            end
            @(negedge clk);
        end
        ld_valid = 1'b0;
    endtask

    task automatic commit_and_wait();
        ncap     = 0;
        busy_cnt = 0;
        commit_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // compare captured page writes with the model
    task automatic check_commit(input string tag);
        int nl = 0;
        for (int l = 0; l < LINES; l++) begin
            bit any = 1'b0;
            for (int b = 0; b < LB; b++) any |= m_v[l*LB+b];
            if (any) nl++;
        end
        chk(busy_cnt == nl * PROG, {tag, " R7 busy cycles"}, 64'(busy_cnt), 64'(nl * PROG));
        chk(ncap == nl, {tag, " R7 page count"}, 64'(ncap), 64'(nl));
        for (int l = 0; l < nl && l < ncap; l++) begin
            logic [LB-1:0]   eben;
            logic [LB*8-1:0] edat;
            logic [LB*8-1:0] amask;
            logic [ADDR_W-4:0] epg;
            epg   = (ADDR_W-3)'((m_base + l) % PAGES);
            eben  = '0;
            edat  = '0;
            amask = '0;
            for (int b = 0; b < LB; b++) begin
                eben[b] = m_v[l*LB+b];
                if (eben[b]) begin
                    edat[b*8 +: 8]  = m_mem[l*LB+b];
                    amask[b*8 +: 8] = 8'hFF;
                end
            end
            chk(cap_page[l] == epg, {tag, " R6 page"}, 64'(cap_page[l]), 64'(epg));
            chk(cap_ben[l] == eben, {tag, " R8 byte enables"}, 64'(cap_ben[l]), 64'(eben));
            chk((cap_data[l] & amask) == edat, {tag, " R3 data"}, cap_data[l] & amask, edat);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy, "R1 busy after reset", 64'(busy), 0);
        chk(!pg_we, "R1 pg_we after reset", 64'(pg_we), 0);

        // R10: commit with nothing loaded
        commit_and_wait();
        chk(busy_cnt == 0, "R10 empty commit busy", 64'(busy_cnt), 0);
        chk(ncap == 0, "R10 empty commit writes", 64'(ncap), 0);

        // table of vectors: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 6; v++) begin
            open_txn(VECS[v].addr);
            load_bytes(int'(VECS[v].nbytes), VECS[v].seed, 1'b1);
            commit_and_wait();
            check_commit($sformatf("vec%0d", v));
        end

        // R5: full load from offset 2 leaves line 0 fully enabled (re-run and inspect)
        open_txn(12'h01A);
        load_bytes(64, 8'd9, 1'b1);
        commit_and_wait();
        chk(cap_ben[0] == 8'hFF, "R5 line0 enables", 64'(cap_ben[0]), 64'hFF);
        chk(cap_data[0][15:0] == {8'(9*37+63), 8'(9*37+62)}, "R5 wrapped bytes",
            64'(cap_data[0][15:0]), 64'({8'(9*37+63), 8'(9*37+62)}));

        // R4: overrun replaces byte 0 of line 0 with byte 64
        open_txn(12'h000);
        load_bytes(65, 8'd7, 1'b1);
        commit_and_wait();
        chk(cap_data[0][7:0] == 8'(7*37+64), "R4 overwrite", 64'(cap_data[0][7:0]), 64'(8'(7*37+64)));

        // R11: reopen discards earlier bytes
        open_txn(12'h040);
        load_bytes(3, 8'd11, 1'b1);
        open_txn(12'h088);
        load_bytes(2, 8'd12, 1'b1);
        commit_and_wait();
        chk(ncap == 1, "R11 pages after reopen", 64'(ncap), 1);
        chk(cap_page[0] == 9'h011, "R11 page after reopen", 64'(cap_page[0]), 64'h11);
        chk(cap_ben[0] == 8'h03, "R11 enables after reopen", 64'(cap_ben[0]), 64'h03);

        // R9: inputs during busy are ignored
        open_txn(12'h200);
        load_bytes(8, 8'd13, 1'b1);
        ncap = 0;
        busy_cnt = 0;
        commit_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0;
        @(negedge clk);
        ld_open = 1'b1;
        ld_addr = 12'h300;
        @(negedge clk);
        ld_open = 1'b0;
        load_bytes(3, 8'd14, 1'b0);
        commit_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(busy_cnt == PROG, "R9 busy not extended", 64'(busy_cnt), 64'(PROG));
        chk(ncap == 1, "R9 single page", 64'(ncap), 1);
        chk(cap_page[0] == 9'h040, "R9 page unchanged", 64'(cap_page[0]), 64'h40);
        // R10: map cleared after commit, so nothing more to write
        commit_and_wait();
        chk(ncap == 0, "R10 repeat commit writes", 64'(ncap), 0);
        chk(busy_cnt == 0, "R10 repeat commit busy", 64'(busy_cnt), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule